// File: doc/BRIEF.md
# Local Bus Cell Transfer Scheduler

This block schedules cell moves on the local bus of one switching module. Five source queues feed it: four local input queues, one per port of the module, and one queue for cells that arrive over the inter-module bus. Five destination queues take its output: four local output queues and one queue for cells that leave for another module. Each source tells the scheduler whether it holds a complete cell. It also presents the target output port and a priority value, both taken from the header of its head cell. Each destination tells the scheduler whether it has room for a complete cell.

In an idle cycle the scheduler finds the source-destination pairs that can move a cell. It picks one source by priority, and breaks ties round-robin. It then holds the bus for one whole cell of fourteen 32-bit words. During that time it pops one word from the chosen source each cycle and pushes the same word into the chosen destination. Routing works on the target port number. The upper bits give the module index and the two low bits give the local lane. A cell that came in over the inter-module bus always goes to a local lane.

Top module: `cell_bus_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after reset is released, every `src_rd_en` and `dst_wr_en` bit is 0.
- R2: A granted cell occupies the bus for exactly 14 consecutive cycles. In each of those cycles `dst_wr_data` equals the word the granted source presents on its `src_rd_data` slice.
- R3: A source is granted only if, in the arbitration cycle, its `src_cell_rdy` bit is 1 and the `dst_room` bit of its routed destination is 1. With no such source, the bus stays idle.
- R4: A cell from a local input queue (source index 0..3) whose port number has module index (port >> 2) equal to `MODULE_ID` is written to destination index port & 3.
- R5: A cell from a local input queue whose module index differs from `MODULE_ID` is written to destination index 4, the outbound queue.
- R6: A cell from source index 4, the inbound queue, is written to destination index port & 3, whatever its module index. It never goes to destination 4.
- R7: Among the eligible sources, the one with the largest `src_head_prio` value is granted.
- R8: Among eligible sources that share the largest priority, the grant goes to the first one found scanning upward from (last granted index + 1) mod 5. After reset the scan starts at index 0.
- R9: A grant is registered in an idle cycle, and its first word moves in the next cycle. Input changes during a transfer do not alter or cut short the cell in progress. At least one idle cycle separates two cells.
- R10: In any cycle at most one `src_rd_en` bit and at most one `dst_wr_en` bit are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_cell_rdy | input | 5 | Per source: at least one complete cell is queued |
| src_head_port | input | 30 | Per source, 6 bits each: target output port of the head cell |
| src_head_prio | input | 15 | Per source, 3 bits each: priority of the head cell |
| src_rd_data | input | 160 | Per source, 32 bits each: word at the queue head (show-ahead) |
| src_rd_en | output | 5 | Per source: pop one word this cycle |
| dst_room | input | 5 | Per destination: space for one complete cell |
| dst_wr_en | output | 5 | Per destination: push `dst_wr_data` this cycle |
| dst_wr_data | output | 32 | Shared bus word |

## Verification
Some properties are checked in every cycle: that only one source and one destination are active at a time, that a cell lasts exactly fourteen cycles, and that the enables hold steady within a cell. They also check that the inbound queue never feeds the outbound queue, that a transfer starts only on a source and destination that were ready in the cycle before, and that no eligible source outranks the granted one. Other behaviour can only be shown by the bench's scenarios. These are the exact local lane and module decode, the round-robin order among equal priorities, that a higher-priority arrival during a transfer does not preempt it, and the word-by-word data path.

// File: rtl/cbs_pkg.sv
// Package: shared types and helpers for the local bus cell scheduler.
// Assumes nothing beyond the standard; no parameters live here.
package cbs_pkg;

    // Transfer engine state: waiting for a grant, or moving a cell.
    typedef enum logic [0:0] {
        MV_IDLE = 1'b0,
        MV_BUSY = 1'b1
    } mv_state_e;

    // Next index in a ring of n entries.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/cbs_route.sv
// Route decode for one source queue.
// Maps the head cell's target port to a destination queue index.
// Assumes NUM_LOCAL is a power of two, so the lane is the low bits of
// the port and the module index is the remaining upper bits.
// FROM_GLOBAL marks the inbound queue: its cells always stay local.
module cbs_route #(
    parameter int NUM_LOCAL   = 4,
    parameter int PORT_W      = 6,
    parameter int MODULE_ID   = 2,
    parameter int IDX_W       = 3,
    parameter bit FROM_GLOBAL = 1'b0
) (
    input  logic [PORT_W-1:0] head_port,
    output logic [IDX_W-1:0]  dest_idx
);
    localparam int LANE_W = $clog2(NUM_LOCAL);
    localparam int MOD_W  = PORT_W - LANE_W;

    logic [LANE_W-1:0] lane;
    logic [MOD_W-1:0]  mod_of;
    logic              is_home;

    assign lane    = head_port[LANE_W-1:0];
    assign mod_of  = head_port[PORT_W-1:LANE_W];
    assign is_home = (mod_of == MOD_W'(MODULE_ID));

    // Pick the local lane for home-module or inbound cells, else the outbound queue.
    always_comb begin
        if (FROM_GLOBAL || is_home)
            dest_idx = IDX_W'(lane);
        else
            dest_idx = IDX_W'(NUM_LOCAL);
    end

endmodule

// File: rtl/cbs_arbiter.sv
// Priority arbiter with round-robin tie break.
// Finds the largest priority among eligible requesters, then takes the
// first requester at that priority scanning upward from rr_ptr.
// rr_ptr moves to one past the winner whenever the grant is taken.
// Assumes take is only raised while gnt_valid is high.
module cbs_arbiter #(
    parameter int N      = 5,
    parameter int PRIO_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      elig,
    input  logic [N*PRIO_W-1:0] prio_flat,
    input  logic              take,
    output logic              gnt_valid,
    output logic [IDX_W-1:0]  gnt_idx
);
    import cbs_pkg::*;

    logic [PRIO_W-1:0] pr [N];
    logic [PRIO_W-1:0] top_prio;
    logic [N-1:0]      cand;
    logic [IDX_W-1:0]  rr_ptr;

    for (genvar g = 0; g < N; g++) begin : g_prio
        assign pr[g] = prio_flat[g*PRIO_W +: PRIO_W];
    end

    // Largest priority over the eligible set, and the requesters holding it.
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (pr[i] > top_prio))
                top_prio = pr[i];
        end
        for (int i = 0; i < N; i++) begin
            cand[i] = elig[i] && (pr[i] == top_prio);
        end
    end

    // Round-robin scan of the candidates starting at rr_ptr.
    always_comb begin
        logic found;
        found     = 1'b0;
        gnt_idx   = '0;
        gnt_valid = |elig;
        for (int off = 0; off < N; off++) begin
            int unsigned idx;
            idx = int'(rr_ptr) + off;
            if (idx >= N)
                idx = idx - N;
            if (!found && cand[idx]) begin
                found   = 1'b1;
                gnt_idx = IDX_W'(idx);
            end
        end
    end

    // Advance the round-robin pointer past each taken grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (take)
            rr_ptr <= IDX_W'(wrap_inc(int'(gnt_idx), N));
    end

    // Any eligible requester ranked above the granted one.
    logic beaten;
    always_comb begin
        beaten = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (pr[i] > pr[gnt_idx]))
                beaten = 1'b1;
        end
    end

    // R3
    grant_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> elig[gnt_idx]);

    // R7
    grant_top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !beaten);

endmodule

// File: rtl/cbs_mover.sv
// Cell transfer engine.
// In an idle cycle it latches a valid grant, then drives the read
// enable of the source and the write enable of the destination for
// WORDS cycles. The bus word passes straight from the source head to the
// destination (show-ahead queues). It returns to idle after the last word.
module cbs_mover #(
    parameter int N      = 5,
    parameter int DATA_W = 32,
    parameter int WORDS  = 14,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gnt_valid,
    input  logic [IDX_W-1:0]    gnt_src,
    input  logic [IDX_W-1:0]    gnt_dst,
    input  logic [N*DATA_W-1:0] src_rd_data,
    output logic                take,
    output logic [N-1:0]        src_rd_en,
    output logic [N-1:0]        dst_wr_en,
    output logic [DATA_W-1:0]   dst_wr_data
);
    import cbs_pkg::*;

    localparam int CNT_W = $clog2(WORDS);

    mv_state_e        state;
    logic [CNT_W-1:0] word_cnt;
    logic [IDX_W-1:0] cur_src;
    logic [IDX_W-1:0] cur_dst;

    assign take = (state == MV_IDLE) && gnt_valid;

    // Hold the bus for one cell, counting words until the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MV_IDLE;
            word_cnt <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
        end else if (state == MV_IDLE) begin
            if (gnt_valid) begin
                state    <= MV_BUSY;
                word_cnt <= '0;
                cur_src  <= gnt_src;
                cur_dst  <= gnt_dst;
            end
        end else begin
            if (word_cnt == CNT_W'(WORDS - 1)) begin
                state    <= MV_IDLE;
                word_cnt <= '0;
            end else begin
                word_cnt <= word_cnt + 1'b1;
            end
        end
    end

    // Drive the enables and the bus word for the active pair.
    always_comb begin
        src_rd_en   = '0;
        dst_wr_en   = '0;
        dst_wr_data = src_rd_data[cur_src*DATA_W +: DATA_W];
        if (state == MV_BUSY) begin
            src_rd_en = N'(1) << cur_src;
            dst_wr_en = N'(1) << cur_dst;
        end
    end

    // Length of the current run of bus activity, kept for the checks below.
    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (|src_rd_en)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    // R10
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_rd_en));

    // R10
    one_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_wr_en));

    // R2
    cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|src_rd_en) |-> (run_len == (CNT_W+1)'(WORDS)));

    // R2
    cell_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_rd_en) |-> (run_len < (CNT_W+1)'(WORDS)));

    // R9
    pair_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src_rd_en) && (run_len != '0)) |-> ($stable(src_rd_en) && $stable(dst_wr_en)));

endmodule

// File: rtl/cell_bus_sched.sv
// Local bus cell transfer scheduler for one switching module.
// Sources 0..NUM_LOCAL-1 are local input queues; source NUM_LOCAL is
// the inbound queue from the inter-module bus. Destinations use the
// same numbering, with NUM_LOCAL as the outbound queue. Each source is
// eligible when it holds a full cell and its routed destination has
// room for one. The arbiter picks one and the mover carries the cell.
module cell_bus_sched #(
    parameter int NUM_LOCAL = 4,
    parameter int PORT_W    = 6,
    parameter int PRIO_W    = 3,
    parameter int DATA_W    = 32,
    parameter int WORDS     = 14,
    parameter int MODULE_ID = 2,
    localparam int NQ       = NUM_LOCAL + 1,
    localparam int IDX_W    = $clog2(NQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NQ-1:0]        src_cell_rdy,
    input  logic [NQ*PORT_W-1:0] src_head_port,
    input  logic [NQ*PRIO_W-1:0] src_head_prio,
    input  logic [NQ*DATA_W-1:0] src_rd_data,
    output logic [NQ-1:0]        src_rd_en,
    input  logic [NQ-1:0]        dst_room,
    output logic [NQ-1:0]        dst_wr_en,
    output logic [DATA_W-1:0]    dst_wr_data
);
    logic [IDX_W-1:0] dest_idx [NQ];
    logic [NQ-1:0]    elig;
    logic             gnt_valid;
    logic [IDX_W-1:0] gnt_idx;
    logic [IDX_W-1:0] gnt_dst;
    logic             take;

    // Route decode and eligibility per source; the last one is the inbound queue.
    for (genvar g = 0; g < NQ; g++) begin : g_src
        cbs_route #(
            .NUM_LOCAL  (NUM_LOCAL),
            .PORT_W     (PORT_W),
            .MODULE_ID  (MODULE_ID),
            .IDX_W      (IDX_W),
            .FROM_GLOBAL(g == NUM_LOCAL)
        ) route_i (
            .head_port(src_head_port[g*PORT_W +: PORT_W]),
            .dest_idx (dest_idx[g])
        );
        assign elig[g] = src_cell_rdy[g] & dst_room[dest_idx[g]];
    end

    assign gnt_dst = dest_idx[gnt_idx];

    cbs_arbiter #(
        .N     (NQ),
        .PRIO_W(PRIO_W),
        .IDX_W (IDX_W)
    ) arb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .prio_flat(src_head_prio),
        .take     (take),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    cbs_mover #(
        .N     (NQ),
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) mover_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_valid  (gnt_valid),
        .gnt_src    (gnt_idx),
        .gnt_dst    (gnt_dst),
        .src_rd_data(src_rd_data),
        .take       (take),
        .src_rd_en  (src_rd_en),
        .dst_wr_en  (dst_wr_en),
        .dst_wr_data(dst_wr_data)
    );

    // R6
    inbound_stays_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en[NUM_LOCAL] |-> !dst_wr_en[NUM_LOCAL]);

    // R3
    start_was_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|src_rd_en) |-> (((src_rd_en & $past(src_cell_rdy)) != '0) &&
                               ((dst_wr_en & $past(dst_room)) != '0)));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> ((src_rd_en == '0) && (dst_wr_en == '0)));

endmodule

// File: tb/cell_bus_sched_tb.sv
// Bench for the local bus cell scheduler: directed corners plus seeded random cases.
module cell_bus_sched_tb_top;
    localparam int NQ  = 5;
    localparam int PW  = 6;
    localparam int MOD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rdy = '0;
    logic [4:0]  room = '1;
    logic [5:0]  port [NQ];
    logic [2:0]  prio [NQ];
    logic [31:0] dat  [NQ];
    logic [NQ*PW-1:0] port_flat;
    logic [NQ*3-1:0]  prio_flat;
    logic [NQ*32-1:0] dat_flat;
    logic [4:0]  src_rd_en, dst_wr_en;
    logic [31:0] dst_wr_data;

    int checks = 0;
    int fails  = 0;
    int rr     = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NQ; s++) begin
            port_flat[s*PW +: PW] = port[s];
            prio_flat[s*3 +: 3]   = prio[s];
            dat_flat[s*32 +: 32]  = dat[s];
        end
    end

    cell_bus_sched #(.MODULE_ID(MOD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_cell_rdy(rdy), .src_head_port(port_flat), .src_head_prio(prio_flat),
        .src_rd_data(dat_flat), .src_rd_en(src_rd_en),
        .dst_room(room), .dst_wr_en(dst_wr_en), .dst_wr_data(dst_wr_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Destination from the routing rules R4/R5/R6.
    function automatic int exp_dest(input int s, input int p);
        if (s == 4) return p % 4;
        if (p / 4 == MOD) return p % 4;
        return 4;
    endfunction

    // Expected winner from R3/R7/R8, or -1 when nothing is eligible.
    function automatic int exp_src();
        int best, win;
        best = -1; win = -1;
        for (int s = 0; s < NQ; s++)
            if (rdy[s] && room[exp_dest(s, int'(port[s]))] && int'(prio[s]) > best)
                best = int'(prio[s]);
        for (int off = 0; off < NQ; off++) begin
            int s;
            s = (rr + off) % NQ;
            if (win < 0 && rdy[s] && room[exp_dest(s, int'(port[s]))] && int'(prio[s]) == best)
                win = s;
        end
        return win;
    endfunction

    // Inputs are already applied; follow one arbitration and its cell.
    task automatic run_case(input string tag, input bit intrude);
        int es, ed, seen, bad;
        es = exp_src();
        if (es < 0) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1;
                chk(src_rd_en == 0 && dst_wr_en == 0, {tag, " R3 idle"}, src_rd_en, 0);
            end
            rdy = '0;
            return;
        end
        ed = exp_dest(es, int'(port[es]));
        seen = 0; bad = 0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            for (int s = 0; s < NQ; s++) dat[s] = $urandom;
            if (intrude && k == 4) begin
                rdy = '1; room = '1;
                for (int s = 0; s < NQ; s++) prio[s] = (s == es) ? 3'd0 : 3'd7;
            end
            #1;
            if (src_rd_en == 5'(1 << es) && dst_wr_en == 5'(1 << ed)) seen++;
            if (dst_wr_data != dat[es]) bad++;
        end
        chk(seen == 14, {tag, " R2 R10 pair"}, {src_rd_en, dst_wr_en}, {5'(1 << es), 5'(1 << ed)});
        chk(bad == 0, {tag, " R2 data"}, bad, 0);
        @(negedge clk); #1;
        chk(src_rd_en == 0 && dst_wr_en == 0, {tag, " R9 gap"}, src_rd_en, 0);
        rdy = '0;
        rr = (es + 1) % NQ;
    endtask

    task automatic set_src(input int s, input int p, input int pr);
        rdy[s] = 1'b1; port[s] = 6'(p); prio[s] = 3'(pr);
    endtask

    initial begin
        void'($urandom(32'h5eed_0c11));
        for (int s = 0; s < NQ; s++) begin port[s] = '0; prio[s] = '0; dat[s] = '0; end
        // R1: held in reset with everything ready.
        rdy = '1; room = '1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(src_rd_en == 0 && dst_wr_en == 0, "R1 reset", {src_rd_en, dst_wr_en}, 0);
        end
        rdy = '0;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(src_rd_en == 0 && dst_wr_en == 0, "R1 after release", src_rd_en, 0);

        // R4: home-module cell to its lane.
        set_src(1, MOD*4 + 3, 0);
        run_case("R4", 1'b0);
        // R5: other-module cell to the outbound queue.
        set_src(0, 5, 0);
        run_case("R5", 1'b0);
        // R6: inbound cell with a foreign module index stays local.
        set_src(4, 62, 0);
        run_case("R6", 1'b0);
        // R7: highest priority wins.
        for (int s = 0; s < 4; s++) set_src(s, MOD*4 + s, 1);
        set_src(4, 0, 1);
        prio[3] = 3'd5;
        run_case("R7", 1'b0);
        // R8: equal priorities rotate.
        for (int n = 0; n < 6; n++) begin
            for (int s = 0; s < 4; s++) set_src(s, MOD*4 + s, 2);
            set_src(4, 1, 2);
            run_case("R8", 1'b0);
        end
        // R3: destination without room blocks the grant.
        room = '1; room[1] = 1'b0;
        set_src(0, MOD*4 + 1, 7);
        run_case("R3 blocked", 1'b0);
        set_src(0, MOD*4 + 1, 7);
        set_src(2, MOD*4 + 2, 0);
        run_case("R3 bypass", 1'b0);
        room = '1;
        // R9: no preemption by a higher-priority arrival.
        set_src(2, 0, 1);
        run_case("R9 intrude", 1'b1);

        // Random mix.
        for (int n = 0; n < 80; n++) begin
            for (int s = 0; s < NQ; s++) begin
                rdy[s]  = ($urandom % 3) != 0;
                port[s] = ($urandom % 2) ? 6'(MOD*4 + $urandom % 4) : 6'($urandom);
                prio[s] = 3'($urandom % 4);
            end
            room = 5'($urandom) | 5'($urandom);
            run_case("random", 1'b0);
            room = '1;
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule